// File: doc/BRIEF.md
# I2C Master Clock Pacer

This block generates the clock line of an I2C master. It pulls SCL low through an open-drain enable and otherwise leaves the line released. The low and high parts of every clock are timed by two separate programmable counts. It also issues start, repeated start and stop conditions, and emits one-cycle strobes that tell the data-line logic when to change SDA, when to sample it, when to pull it low and when to release it.

In synchronized mode the pacer watches the sampled SCL line. A high phase is only timed once the line is seen high, so any device that holds SCL low stretches the clock. If another master pulls the line low during a local high phase, that phase ends at once. In bypass mode the line level is ignored and the programmed rate is produced exactly. This mode exists only to check the programmed rate while debugging.

Commands are given as a one-cycle `cmd_valid` with an operation code. Between a start and a stop the pacer holds SCL low while it waits for the next command.

Top module: `i2c_scl_pacer`

## Requirements
- R1: During and right after synchronous reset, `scl_pull`, `busy`, `done` and all four SDA strobes are 0, and the pacer is idle with SCL released.
- R2: With `sync_en`=0, a data bit (`cmd_op`=0) accepted at edge A releases SCL after L cycles and pulls it low again after H more cycles. L and H are the effective low and high counts. `done` pulses in the cycle SCL is pulled. The sampled line level has no effect.
- R3: With `sync_en`=1, after release the high count starts only in the cycle after the line is first seen high. The line is therefore high for H+1 cycles however long another device held it low.
- R4: With `sync_en`=1, if the line is seen low while a high phase is being timed, `scl_pull` is asserted in the next cycle together with `done`.
- R5: Start (`cmd_op`=1) is accepted only when idle with the line high. It pulses `sda_start` in the first cycle after acceptance and pulls SCL low H cycles later, with `done`.
- R6: Stop (`cmd_op`=3) times a low phase of L cycles and then a high phase (plus one line-sampling cycle when synchronized). It then pulses `sda_stop` and `done`, and leaves SCL released with `busy`=0.
- R7: Repeated start (`cmd_op`=2) times a low phase, then a setup high phase of H cycles (plus one sampling cycle when synchronized). It then pulses `sda_start` and pulls SCL low H cycles after that strobe.
- R8: `sda_chg` pulses in the first cycle after a bit, stop or repeated start is accepted. `sda_smp` pulses once per data bit, in the first cycle of its timed high phase. At most one SDA strobe is active in any cycle.
- R9: These commands are ignored: a bit, stop or repeated start while idle; a start while holding SCL low; any command while `busy` is 1.
- R10: A count of 0 in `hi_len` or `lo_len` acts as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_len | input | CW | High-phase length in clock cycles (0 acts as 1) |
| lo_len | input | CW | Low-phase length in clock cycles (0 acts as 1) |
| sync_en | input | 1 | 1: follow the SCL line level; 0: run free (debug) |
| scl_in | input | 1 | Sampled SCL line level |
| cmd_valid | input | 1 | One-cycle command request |
| cmd_op | input | 2 | 0 bit, 1 start, 2 repeated start, 3 stop |
| scl_pull | output | 1 | Open-drain enable: 1 pulls SCL low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| sda_chg | output | 1 | Strobe: SCL is low, SDA may change |
| sda_smp | output | 1 | Strobe: SCL high, sample SDA |
| sda_start | output | 1 | Strobe: pull SDA low while SCL is high |
| sda_stop | output | 1 | Strobe: release SDA while SCL is high |

## Verification
The assertions assume that `scl_in` goes low whenever `scl_pull` is set. They also assume that `sync_en`, `hi_len` and `lo_len` do not change while `busy` is high. The bench models the line as the wired AND of the pacer's own pull and a bench-driven external pull. It changes the configuration only between commands, when the pacer is idle or holding. It drives the external pull only in the directed stretch, cut-short and bypass cases, where that pull stands in for another device.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

  typedef enum logic [1:0] {
    OP_BIT     = 2'd0,
    OP_START   = 2'd1,
    OP_RESTART = 2'd2,
    OP_STOP    = 2'd3
  } scl_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,    // bus free, SCL released
    ST_HOLD,    // between commands, SCL held low
    ST_LOW,     // timed low phase
    ST_WAITHI,  // SCL released, waiting to see the line high
    ST_HIGH,    // timed high phase
    ST_SWAIT,   // start requested, waiting for a free line
    ST_SHOLD    // start hold: SDA low, SCL high
  } scl_st_e;

endpackage

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - ONE;
    end else if (cnt != '0) begin
      cnt <= cnt - ONE;
    end
  end

  assign expired = (cnt == '0);

  // R10: a zero length gives a one-cycle phase
  a_r10_zero_len: assert property (@(posedge clk) disable iff (rst)
    (load && len == '0) |=> expired);

endmodule

// File: rtl/scl_line_qual.sv
module scl_line_qual (
  input  logic sync_en,
  input  logic scl_in,
  output logic wait_line,
  output logic hi_ok,
  output logic cut
);
  // after a release, a synchronized pacer must see the line before timing
  assign wait_line = sync_en;
  // line counts as high when it is really high, or when it is ignored
  assign hi_ok     = !sync_en || scl_in;
  // another device pulled SCL low while this pacer released it
  assign cut       = sync_en && !scl_in;
endmodule

// File: rtl/scl_pacer_fsm.sv
module scl_pacer_fsm
  import scl_pacer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  scl_op_e cmd_op,
  input  logic    wait_line,
  input  logic    hi_ok,
  input  logic    cut,
  input  logic    tmr_exp,
  output logic    tmr_load,
  output logic    tmr_hi,
  output logic    scl_pull,
  output logic    busy,
  output logic    done,
  output logic    sda_chg,
  output logic    sda_smp,
  output logic    sda_start,
  output logic    sda_stop
);
  scl_st_e st, st_n;
  scl_op_e op_q, op_n;
  logic    accept;
  logic    done_n, chg_n, smp_n, start_n, stop_n;

  assign accept = cmd_valid &&
                  (((st == ST_IDLE) && (cmd_op == OP_START)) ||
                   ((st == ST_HOLD) && (cmd_op != OP_START)));

  always_comb begin
    st_n     = st;
    op_n     = op_q;
    tmr_load = 1'b0;
    tmr_hi   = 1'b0;
    done_n   = 1'b0;
    chg_n    = 1'b0;
    smp_n    = 1'b0;
    start_n  = 1'b0;
    stop_n   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          op_n = OP_START;
          if (hi_ok) begin
            st_n     = ST_SHOLD;
            tmr_load = 1'b1;
            tmr_hi   = 1'b1;
            start_n  = 1'b1;
          end else begin
            st_n = ST_SWAIT;
          end
        end
      end
      ST_SWAIT: begin
        if (hi_ok) begin
          st_n     = ST_SHOLD;
          tmr_load = 1'b1;
          tmr_hi   = 1'b1;
          start_n  = 1'b1;
        end
      end
      ST_SHOLD: begin
        if (tmr_exp) begin
          st_n   = ST_HOLD;
          done_n = 1'b1;
        end
      end
      ST_HOLD: begin
        if (accept) begin
          op_n     = cmd_op;
          st_n     = ST_LOW;
          tmr_load = 1'b1;
          chg_n    = 1'b1;
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          if (wait_line) begin
            st_n = ST_WAITHI;
          end else begin
            st_n     = ST_HIGH;
            tmr_load = 1'b1;
            tmr_hi   = 1'b1;
            smp_n    = (op_q == OP_BIT);
          end
        end
      end
      ST_WAITHI: begin
        if (hi_ok) begin
          st_n     = ST_HIGH;
          tmr_load = 1'b1;
          tmr_hi   = 1'b1;
          smp_n    = (op_q == OP_BIT);
        end
      end
      ST_HIGH: begin
        if (cut) begin
          st_n   = ST_HOLD;
          done_n = 1'b1;
        end else if (tmr_exp) begin
          unique case (op_q)
            OP_STOP: begin
              st_n   = ST_IDLE;
              stop_n = 1'b1;
              done_n = 1'b1;
            end
            OP_RESTART: begin
              st_n     = ST_SHOLD;
              tmr_load = 1'b1;
              tmr_hi   = 1'b1;
              start_n  = 1'b1;
            end
            default: begin
              st_n   = ST_HOLD;
              done_n = 1'b1;
            end
          endcase
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_q      <= OP_BIT;
      scl_pull  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      sda_chg   <= 1'b0;
      sda_smp   <= 1'b0;
      sda_start <= 1'b0;
      sda_stop  <= 1'b0;
    end else begin
      st        <= st_n;
      op_q      <= op_n;
      scl_pull  <= (st_n == ST_HOLD) || (st_n == ST_LOW);
      busy      <= !((st_n == ST_IDLE) || (st_n == ST_HOLD));
      done      <= done_n;
      sda_chg   <= chg_n;
      sda_smp   <= smp_n;
      sda_start <= start_n;
      sda_stop  <= stop_n;
    end
  end

  // R4: a low line during a timed high phase ends it in the next cycle
  a_r4_cut_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HIGH && cut) |=> (scl_pull && done));

  // R3: a held-low line keeps the pacer waiting with SCL released
  a_r3_stretch_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAITHI && !hi_ok) |=> (st == ST_WAITHI && !scl_pull));

  // R9: commands other than start are ignored while idle
  a_r9_idle_ignore: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && cmd_valid && cmd_op != OP_START) |=> (st == ST_IDLE && !busy));

  // R6: the stop strobe leaves SCL released and the pacer free
  a_r6_stop_free: assert property (@(posedge clk) disable iff (rst)
    sda_stop |-> (!scl_pull && !busy));

  // R8: never two SDA strobes in one cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sda_chg, sda_smp, sda_start, sda_stop}));

endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import scl_pacer_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  input  logic          sync_en,
  input  logic          scl_in,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  output logic          scl_pull,
  output logic          busy,
  output logic          done,
  output logic          sda_chg,
  output logic          sda_smp,
  output logic          sda_start,
  output logic          sda_stop
);
  logic          wait_line, hi_ok, cut;
  logic          tmr_load, tmr_hi, tmr_exp;
  logic [CW-1:0] tmr_len;

  assign tmr_len = tmr_hi ? hi_len : lo_len;

  scl_line_qual u_line (
    .sync_en   (sync_en),
    .scl_in    (scl_in),
    .wait_line (wait_line),
    .hi_ok     (hi_ok),
    .cut       (cut)
  );

  scl_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_exp)
  );

  scl_pacer_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (scl_op_e'(cmd_op)),
    .wait_line (wait_line),
    .hi_ok     (hi_ok),
    .cut       (cut),
    .tmr_exp   (tmr_exp),
    .tmr_load  (tmr_load),
    .tmr_hi    (tmr_hi),
    .scl_pull  (scl_pull),
    .busy      (busy),
    .done      (done),
    .sda_chg   (sda_chg),
    .sda_smp   (sda_smp),
    .sda_start (sda_start),
    .sda_stop  (sda_stop)
  );

  // R1: cycle after reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!scl_pull && !busy && !done));

endmodule

// File: tb/test_i2c_scl_pacer.sv
module test_i2c_scl_pacer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] hi_len = 8'd3;
  logic [7:0] lo_len = 8'd3;
  logic       sync_en = 1'b1;
  logic       ext_low = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       scl_in;
  logic       scl_pull, busy, done, sda_chg, sda_smp, sda_start, sda_stop;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_fall, t_rise, t_smp, t_chg, t_lstb, t_rstb, t_done;
  logic prev_pull = 1'b0;

  assign scl_in = !scl_pull && !ext_low;

  i2c_scl_pacer #(.CW(8)) i_i2c_scl_pacer (
    .clk(clk), .rst(rst), .hi_len(hi_len), .lo_len(lo_len),
    .sync_en(sync_en), .scl_in(scl_in), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .scl_pull(scl_pull), .busy(busy), .done(done),
    .sda_chg(sda_chg), .sda_smp(sda_smp), .sda_start(sda_start),
    .sda_stop(sda_stop));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (prev_pull && !scl_pull) t_fall = cyc;
    if (!prev_pull && scl_pull) t_rise = cyc;
    if (sda_smp)   t_smp  = cyc;
    if (sda_chg)   t_chg  = cyc;
    if (sda_start) t_lstb = cyc;
    if (sda_stop)  t_rstb = cyc;
    if (done)      t_done = cyc;
    prev_pull = scl_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  task automatic clear_stamps();
    t_fall = -1; t_rise = -1; t_smp = -1; t_chg = -1;
    t_lstb = -1; t_rstb = -1; t_done = -1;
  endtask

  // issue one command; poke>=2 drives a stray stop request while busy
  task automatic issue(input logic [1:0] op, input int poke, output int acc);
    bit ok = 0;
    clear_stamps();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; acc = cyc + 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (i == poke) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
      else cmd_valid = 1'b0;
      if (done) begin ok = 1; break; end
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(ok, "R2 done seen", int'(ok), 1);
  endtask

  task automatic check_bit(input int acc);
    int w = sync_en ? 1 : 0;
    int f = acc + eff(lo_len);
    chk(t_chg == acc, "R8 chg at accept", t_chg, acc);
    chk(t_fall == f, "R2 low phase length", t_fall, f);
    chk(t_smp == f + w, "R8 smp first high cycle", t_smp, f + w);
    chk(t_rise == f + w + eff(hi_len), "R3 high phase length", t_rise, f + w + eff(hi_len));
    chk(t_done == t_rise, "R2 done with pull", t_done, t_rise);
  endtask

  task automatic check_start(input int acc);
    chk(t_lstb == acc, "R5 start strobe", t_lstb, acc);
    chk(t_rise == acc + eff(hi_len), "R5 start hold", t_rise, acc + eff(hi_len));
    chk(t_done == t_rise, "R5 done", t_done, t_rise);
  endtask

  task automatic check_stop(input int acc);
    int w = sync_en ? 1 : 0;
    int f = acc + eff(lo_len);
    chk(t_chg == acc, "R8 chg on stop", t_chg, acc);
    chk(t_fall == f, "R6 stop low", t_fall, f);
    chk(t_rstb == f + w + eff(hi_len), "R6 stop strobe", t_rstb, f + w + eff(hi_len));
    chk(t_done == t_rstb, "R6 done", t_done, t_rstb);
    chk(!scl_pull && !busy, "R6 released idle", int'(scl_pull), 0);
  endtask

  task automatic check_restart(input int acc);
    int w = sync_en ? 1 : 0;
    int f = acc + eff(lo_len);
    int s = f + w + eff(hi_len);
    chk(t_chg == acc, "R8 chg on restart", t_chg, acc);
    chk(t_fall == f, "R7 restart low", t_fall, f);
    chk(t_lstb == s, "R7 restart strobe", t_lstb, s);
    chk(t_rise == s + eff(hi_len), "R7 restart hold", t_rise, s + eff(hi_len));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    int c;
    int s;
    logic [31:0] seed;
    seed = $urandom(32'd1234);

    repeat (4) @(negedge clk);
    chk(!scl_pull && !busy && !done, "R1 reset outputs", int'(scl_pull), 0);
    chk(!(sda_chg || sda_smp || sda_start || sda_stop), "R1 strobes", 1, 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: bit request while idle is ignored
    clear_stamps();
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !scl_pull && t_chg == -1, "R9 idle bit ignored", int'(busy), 0);

    // R5 start, synchronized
    sync_en = 1'b1; hi_len = 8'd4; lo_len = 8'd3;
    issue(2'd1, -1, acc); check_start(acc);

    // R9: start while holding is ignored
    cmd_valid = 1'b1; cmd_op = 2'd1;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_pull && !busy, "R9 start in hold ignored", int'(scl_pull), 1);

    // R9: stray stop while busy does not disturb the bit
    issue(2'd0, 2, acc); check_bit(acc);
    chk(scl_pull && !busy, "R9 busy stop ignored", int'(scl_pull), 1);

    // R2: bypass ignores a line held low
    sync_en = 1'b0; ext_low = 1'b1; hi_len = 8'd5; lo_len = 8'd2;
    issue(2'd0, -1, acc); check_bit(acc);
    ext_low = 1'b0;

    // R3: stretch in synchronized mode
    sync_en = 1'b1; ext_low = 1'b1; hi_len = 8'd3; lo_len = 8'd2;
    clear_stamps();
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0; acc = cyc + 1;
    @(negedge clk); cmd_valid = 1'b0;
    while (scl_pull) @(negedge clk);
    repeat (7) @(negedge clk);
    chk(!busy == 1'b0 && t_smp == -1, "R3 waiting while held", t_smp, -1);
    ext_low = 1'b0; c = cyc;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(t_smp == c + 1, "R3 smp after line high", t_smp, c + 1);
    chk(t_rise == c + 1 + 3, "R3 line high run", t_rise - c, 4);

    // R4: another master cuts the high phase short
    hi_len = 8'd8; lo_len = 8'd2;
    clear_stamps();
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    while (!sda_smp) @(negedge clk);
    ext_low = 1'b1; s = cyc;
    @(negedge clk);
    chk(scl_pull && done, "R4 cut pulls next cycle", int'(scl_pull), 1);
    ext_low = 1'b0;
    @(negedge clk);

    // R10: zero counts act as one
    hi_len = 8'd0; lo_len = 8'd0;
    issue(2'd0, -1, acc); check_bit(acc);
    sync_en = 1'b0;
    issue(2'd0, -1, acc); check_bit(acc);
    issue(2'd2, -1, acc); check_restart(acc);
    issue(2'd3, -1, acc); check_stop(acc);

    // random transactions
    for (int n = 0; n < 40; n++) begin
      sync_en = 1'($urandom_range(0, 1));
      hi_len = 8'($urandom_range(0, 9)); lo_len = 8'($urandom_range(0, 9));
      issue(2'd1, -1, acc); check_start(acc);
      for (int b = 0; b < int'($urandom_range(1, 3)); b++) begin
        hi_len = 8'($urandom_range(0, 9)); lo_len = 8'($urandom_range(0, 9));
        issue(2'd0, -1, acc); check_bit(acc);
      end
      if ($urandom_range(0, 1) == 1) begin
        issue(2'd2, -1, acc); check_restart(acc);
        issue(2'd0, -1, acc); check_bit(acc);
      end
      hi_len = 8'($urandom_range(0, 9)); lo_len = 8'($urandom_range(0, 9));
      issue(2'd3, -1, acc); check_stop(acc);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule